// File: doc/BRIEF.md
# Micro-step Position Sequencer

This block keeps the electrical angle of a two-phase stepper motor as a 7-bit index counted in 1/32 micro-steps, so one electrical turn is 128 counts and the index wraps. An asynchronous step-request line is synchronized and edge-detected. Each qualifying edge moves the index up or down by the increment of the current step mode. A downstream current lookup consumes the index, and a one-cycle strobe marks every update.

The step mode, the register direction bit and the edge polarity bit are level inputs held by a register file. A new step-mode code has no effect until the next step request. That request then uses the new increment at once. When the resolution becomes finer, the index first moves to the nearest point of the finer grid. When it becomes coarser, the index keeps any offset it has from the coarser grid.

Top module: `ustep_position_seq`

## Requirements
- R1: While and right after reset, `pos_idx` is 0 and `pos_upd` is 0. The active step mode after reset is 1/32 (increment 1).
- R2: Position arithmetic is modulo 128. Stepping up from 116 by 32 gives 20, and stepping down from 14 by 32 gives 110.
- R3: With `edge_pol`=1 only a rising edge of `step_req` is a step request; with `edge_pol`=0 only a falling edge is. The other edge leaves `pos_idx` unchanged and `pos_upd` low.
- R4: A qualifying edge of `step_req` that is set up before rising clock edge k gives `pos_upd`=1 and the new `pos_idx` after rising edge k+2.
- R5: `pos_upd` is high for exactly one cycle per step request.
- R6: The index counts up when `dir_pin` XOR `dir_ctrl` is 1 and counts down when it is 0.
- R7: The increment depends on `mode_code`. 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, 3'b100 and 3'b101 give 16, and 3'b110 and 3'b111 give 32.
- R8: A change of `mode_code` without a step request leaves `pos_idx` unchanged. `pos_idx` changes only in a cycle where `pos_upd` is 1.
- R9: When the new increment is smaller than the active one, the step starts from the index rounded to the nearest multiple of the new increment, with a tie rounded up. For example, 11 stepped up at increment 2 gives 14, and 110 stepped up at increment 4 gives 116.
- R10: When the new increment is equal to or larger than the active one, the step is added to the current index with no rounding. For example, 3 stepped up at increment 8 gives 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_req | input | 1 | Asynchronous step-request line |
| dir_pin | input | 1 | Direction input line |
| dir_ctrl | input | 1 | Register direction bit, XORed with `dir_pin` |
| edge_pol | input | 1 | 1: rising edge steps, 0: falling edge steps |
| mode_code | input | 3 | Requested step-mode code |
| pos_idx | output | 7 | Position index in 1/32 micro-steps |
| pos_upd | output | 1 | One-cycle strobe on each position update |

## Verification
Each result arrives a fixed number of clock edges after its stimulus. A step-request edge shows up as `pos_upd` and a new `pos_idx` after the third rising edge that follows it: two synchronizer flops, then the position register. The bench drives every input on a falling edge. It then samples on the third falling edge for the strobe and the new index, and on the fourth falling edge to confirm that the strobe has dropped. A mode change or an edge that does not qualify is observed over several falling edges, and none of them may show an update.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int POS_W  = 7;
    localparam int MODE_W = 3;
    localparam int LG_W   = 3;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [LG_W-1:0]   lg_t;

    typedef enum logic [MODE_W-1:0] {
        MODE_DIV32       = 3'b000,
        MODE_DIV16       = 3'b001,
        MODE_DIV8        = 3'b010,
        MODE_QUARTER     = 3'b011,
        MODE_HALF_COMP   = 3'b100,
        MODE_HALF_UNCOMP = 3'b101,
        MODE_FULL        = 3'b110,
        MODE_FULL_ALT    = 3'b111
    } step_mode_e;

    // Step command handed from mode control to the position accumulator
    typedef struct packed {
        logic up;
        logic snap;
        lg_t  lg_new;
    } step_cmd_t;

    // log2 of the increment for each mode code
    function automatic lg_t mode_lg(step_mode_e m);
        lg_t r;
        case (m)
            MODE_DIV32:       r = 3'd0;
            MODE_DIV16:       r = 3'd1;
            MODE_DIV8:        r = 3'd2;
            MODE_QUARTER:     r = 3'd3;
            MODE_HALF_COMP,
            MODE_HALF_UNCOMP: r = 3'd4;
            default:          r = 3'd5;
        endcase
        return r;
    endfunction

    // Round to nearest multiple of 2**lg, ties upward, modulo 2**POS_W
    function automatic pos_t grid_round(pos_t p, lg_t lg);
        pos_t half;
        pos_t mask;
        if (lg == '0) return p;
        half = pos_t'(1) << (lg - lg_t'(1));
        mask = ~((pos_t'(1) << lg) - pos_t'(1));
        return (p + half) & mask;
    endfunction

endpackage

// File: rtl/ustep_edge_sync.sv
module ustep_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic pol,
    output logic evt
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[gi] <= 1'b0;
                else     chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    assign evt = (chain[LAST] != prev) && (chain[LAST] == pol);

endmodule

// File: rtl/ustep_mode_ctrl.sv
module ustep_mode_ctrl
    import ustep_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      evt,
    input  mode_t     mode_code,
    input  logic      dir_pin,
    input  logic      dir_ctrl,
    output step_cmd_t cmd
);
    lg_t act_lg;
    lg_t req_lg;

    assign req_lg     = mode_lg(step_mode_e'(mode_code));
    assign cmd.lg_new = req_lg;
    assign cmd.snap   = (req_lg < act_lg);
    assign cmd.up     = dir_pin ^ dir_ctrl;

    always_ff @(posedge clk) begin
        if (rst)      act_lg <= '0;
        else if (evt) act_lg <= req_lg;
    end

endmodule

// File: rtl/ustep_pos_acc.sv
module ustep_pos_acc
    import ustep_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      evt,
    input  step_cmd_t cmd,
    output pos_t      pos,
    output logic      upd
);
    pos_t base;
    pos_t stride;
    pos_t nxt;

    assign base   = cmd.snap ? grid_round(pos, cmd.lg_new) : pos;
    assign stride = pos_t'(1) << cmd.lg_new;
    assign nxt    = cmd.up ? (base + stride) : (base - stride);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            upd <= 1'b0;
        end else begin
            upd <= evt;
            if (evt) pos <= nxt;
        end
    end

endmodule

// File: rtl/ustep_position_seq.sv
module ustep_position_seq
    import ustep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_req,
    input  logic             dir_pin,
    input  logic             dir_ctrl,
    input  logic             edge_pol,
    input  logic [MODE_W-1:0] mode_code,
    output logic [POS_W-1:0]  pos_idx,
    output logic             pos_upd
);
    logic      step_evt;
    step_cmd_t cmd;

    ustep_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (step_req),
        .pol (edge_pol),
        .evt (step_evt)
    );

    ustep_mode_ctrl u_mode (
        .clk       (clk),
        .rst       (rst),
        .evt       (step_evt),
        .mode_code (mode_code),
        .dir_pin   (dir_pin),
        .dir_ctrl  (dir_ctrl),
        .cmd       (cmd)
    );

    ustep_pos_acc u_acc (
        .clk (clk),
        .rst (rst),
        .evt (step_evt),
        .cmd (cmd),
        .pos (pos_idx),
        .upd (pos_upd)
    );

endmodule

// File: rtl/ustep_position_seq_chk.sv
module ustep_position_seq_chk #(
    parameter int SYNC_STAGES = 2,
    parameter int POS_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             step_req,
    input logic             edge_pol,
    input logic [POS_W-1:0] pos_idx,
    input logic             pos_upd
);
    localparam int LAT = SYNC_STAGES + 1;
    localparam int WARM = LAT + 2;

    int unsigned live_cnt;
    always_ff @(posedge clk) begin
        if (rst) live_cnt <= 0;
        else if (live_cnt < WARM) live_cnt <= live_cnt + 1;
    end

    // R1: reset clears position and strobe
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pos_idx == '0) && !pos_upd);

    // R4: strobe follows a qualifying input edge after the sync latency
    p_upd_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= WARM) |->
            (pos_upd == (($past(step_req, LAT) != $past(step_req, LAT + 1)) &&
                         ($past(step_req, LAT) == $past(edge_pol, 1)))));

    // R8: the index moves only together with the strobe
    p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 1) && (pos_idx != $past(pos_idx)) |-> pos_upd);

    // R5: strobe lasts a single cycle
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
        pos_upd |=> !pos_upd);

endmodule

bind ustep_position_seq ustep_position_seq_chk #(
    .SYNC_STAGES(SYNC_STAGES),
    .POS_W(ustep_pkg::POS_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step_req (step_req),
    .edge_pol (edge_pol),
    .pos_idx  (pos_idx),
    .pos_upd  (pos_upd)
);

// File: tb/ustep_position_seq_bench.sv
module ustep_position_seq_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_req = 1'b0;
    logic       dir_pin = 1'b0;
    logic       dir_ctrl = 1'b0;
    logic       edge_pol = 1'b1;
    logic [2:0] mode_code = 3'b000;
    logic [6:0] pos_idx;
    logic       pos_upd;

    int n_chk = 0;
    int n_err = 0;
    int m_pos = 0;
    int m_inc = 1;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    ustep_position_seq u_ustep_position_seq (
        .clk(clk), .rst(rst), .step_req(step_req), .dir_pin(dir_pin),
        .dir_ctrl(dir_ctrl), .edge_pol(edge_pol), .mode_code(mode_code),
        .pos_idx(pos_idx), .pos_upd(pos_upd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int inc_of(input logic [2:0] c);
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b100, 3'b101: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic int next_pos(input int p, input int old_inc, input logic [2:0] c, input bit up);
        int ni = inc_of(c);
        int b = p;
        if (ni < old_inc) b = (((p + ni / 2) / ni) * ni) % 128;
        return up ? (b + ni) % 128 : (b - ni + 128) % 128;
    endfunction

    // One step request with the given controls; expected index compared
    task automatic do_step(input bit dp, input bit dc, input bit pol,
                           input logic [2:0] mc, input string req);
        int expv;
        @(negedge clk);
        dir_pin = dp; dir_ctrl = dc; edge_pol = pol; mode_code = mc;
        if (step_req == pol) begin
            step_req = !pol;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(!pos_upd && pos_idx == m_pos, "R3 opposite edge ignored", pos_idx, m_pos);
            end
        end
        step_req = pol;
        expv  = next_pos(m_pos, m_inc, mc, dp ^ dc);
        m_inc = inc_of(mc);
        m_pos = expv;
        @(negedge clk);
        @(negedge clk);
        chk(!pos_upd, "R4 no early strobe", pos_upd, 0);
        @(negedge clk);
        chk(pos_upd, "R4 strobe timing", pos_upd, 1);
        chk(pos_idx == expv, req, pos_idx, expv);
        @(negedge clk);
        chk(!pos_upd, "R5 strobe one cycle", pos_upd, 1'b0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        chk(pos_idx == 0, "R1 reset index", pos_idx, 0);
        chk(!pos_upd, "R1 reset strobe", pos_upd, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Directed corner cases
        do_step(1, 0, 1, 3'b000, "R7 R6 step of 1 up");
        do_step(0, 1, 1, 3'b000, "R6 xor up");
        do_step(1, 0, 0, 3'b000, "R3 falling edge step");
        do_step(1, 0, 1, 3'b011, "R10 offset kept 3->11");
        // R8: mode change alone does nothing
        @(negedge clk); mode_code = 3'b110;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!pos_upd && pos_idx == m_pos, "R8 mode change pending", pos_idx, m_pos);
        end
        do_step(1, 0, 1, 3'b001, "R9 snap 11->14");
        do_step(1, 1, 1, 3'b110, "R2 wrap down 14->110");
        do_step(0, 1, 1, 3'b010, "R9 tie rounds up 110->116");
        do_step(1, 0, 1, 3'b110, "R2 wrap up 116->20");
        do_step(0, 0, 1, 3'b100, "R7 half step down");

        // Mid-run reset
        @(negedge clk); rst = 1'b1; step_req = 1'b0; edge_pol = 1'b1;
        repeat (2) @(negedge clk);
        chk(pos_idx == 0 && !pos_upd, "R1 reset mid-run", pos_idx, 0);
        rst = 1'b0; m_pos = 0; m_inc = 1;
        @(negedge clk);

        // Constrained random
        for (int it = 0; it < 300; it++) begin
            logic [2:0] mc = mode_code;
            if ($urandom_range(3) == 0) mc = 3'($urandom_range(7));
            do_step(1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                    mc, "R7 R9 R10 random step");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule